// File: doc/BRIEF.md
# Latch, Sampling and Periodic Capture Unit

This block sits next to a pulse counter and performs one measurement function at a time on that counter's activity. The host picks the function with a two-bit selection code and launches it with a start command. An external start input can launch it as well. The three functions are:

- **Latch** takes a snapshot of the counter's running value.
- **Sampling** counts the count strobes that arrive during a programmed window.
- **Periodic** records the running value at the end of every programmed period and keeps the value from the period before.

All time settings are counted in millisecond ticks that come from a shared time base. While a sampling or periodic run is in progress, a busy flag is set. All results are 32-bit signed values.

Top module: `pulse_capture_unit`

## Requirements
- R1: After reset, busy is 0 and the latch, sampling, periodic-present and periodic-previous outputs are all 0.
- R2: Function code 0 selects latch. A rising edge of (startCmd OR extStart) then copies the countValue of that cycle into latchValue, which is visible from the next cycle. Busy stays 0.
- R3: Start acts only on its rising edge. Holding start high does not capture again. Code 3 selects no function, so a start edge under code 3 changes no output.
- R4: Function code 1 selects sampling. Busy rises in the cycle after the start edge. Every countPulse seen while busy adds one. On the max(timeSet,1)-th msTick after the start, sampleValue receives the total, including a pulse in that same cycle, and busy falls.
- R5: A timeSet of 0 gives a window of exactly one msTick.
- R6: Function code 2 selects periodic. At each max(timeSet,1)-th msTick the previous output takes the old present value, and the present output takes that cycle's countValue. Timing then restarts.
- R7: A periodic run keeps busy high for as long as startCmd or extStart is high. It clears busy in the cycle after both are low, and it makes no further captures.
- R8: If the function code changes during a run, busy clears in the next cycle and no result output changes.
- R9: A start edge that arrives during a sampling run is ignored. The window still closes at its original time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| countPulse | input | 1 | One-cycle strobe for each counted pulse |
| countValue | input | 32 | Running count of the main counter (signed) |
| funcSel | input | 2 | Function code: 0 latch, 1 sampling, 2 periodic, 3 none |
| startCmd | input | 1 | Start command from the host |
| extStart | input | 1 | External start input |
| timeSet | input | 16 | Window or period length in ms ticks (0 counts as 1) |
| msTick | input | 1 | One-cycle millisecond time base strobe |
| latchValue | output | 32 | Latched count |
| sampleValue | output | 32 | Pulse total of the last sampling window |
| periodPresent | output | 32 | Count captured at the latest period end |
| periodPrevious | output | 32 | Count captured at the period end before that |
| busy | output | 1 | Sampling or periodic run in progress |

## Verification
The in-RTL assertions check the following on every cycle:

- The latch copies exactly the value present at the capture strobe.
- The latch and sample registers do not move without their strobes.
- A periodic shift passes the old present value into the previous value.
- A function-code change drops busy.
- Releasing start ends a periodic run.

Only the bench's scenarios can show the window lengths in ticks, the pulse totals for different pulse densities, the zero-setting case, and the ignoring of a re-start during sampling. The bench sweeps window lengths 0 to 4 against three pulse densities and compares every output in every cycle.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [1:0] {
    FN_LATCH  = 2'd0,
    FN_SAMPLE = 2'd1,
    FN_PERIOD = 2'd2,
    FN_IDLE   = 2'd3
  } fn_e;

  typedef struct packed {
    logic latchCap;
    logic sampClear;
    logic sampAdd;
    logic sampStore;
    logic perShift;
  } strobe_t;
endpackage

// File: rtl/pcu_ctrl.sv
module pcu_ctrl
  import pcu_pkg::*;
#(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              countPulse,
  input  logic [1:0]        funcSel,
  input  logic              startCmd,
  input  logic              extStart,
  input  logic [TIME_W-1:0] timeSet,
  input  logic              msTick,
  output strobe_t           str,
  output logic              busy
);
  fn_e              selNow;
  fn_e              runMode;
  logic             startPrev;
  logic             startReq;
  logic             startEdge;
  logic             abortRun;
  logic             lastTick;
  logic [TIME_W-1:0] elapsed;
  logic [TIME_W-1:0] effTime;

  assign selNow    = fn_e'(funcSel);
  assign startReq  = startCmd | extStart;
  assign startEdge = startReq & ~startPrev;
  assign effTime   = (timeSet == '0) ? TIME_W'(1) : timeSet;
  assign lastTick  = msTick && (elapsed == effTime - TIME_W'(1));
  assign abortRun  = busy && (selNow != runMode);

  always_comb begin
    str           = '0;
    str.latchCap  = !busy && startEdge && (selNow == FN_LATCH);
    str.sampClear = !busy && startEdge && (selNow == FN_SAMPLE);
    str.sampAdd   = busy && !abortRun && (runMode == FN_SAMPLE) && countPulse;
    str.sampStore = busy && !abortRun && (runMode == FN_SAMPLE) && lastTick;
    str.perShift  = busy && !abortRun && (runMode == FN_PERIOD) && startReq && lastTick;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      runMode   <= FN_IDLE;
      startPrev <= 1'b0;
      elapsed   <= '0;
    end else begin
      startPrev <= startReq;
      if (abortRun) begin
        busy <= 1'b0;
      end else if (!busy) begin
        if (startEdge && (selNow == FN_SAMPLE || selNow == FN_PERIOD)) begin
          busy    <= 1'b1;
          runMode <= selNow;
          elapsed <= '0;
        end
      end else if (runMode == FN_PERIOD && !startReq) begin
        busy <= 1'b0;
      end else if (msTick) begin
        if (lastTick) begin
          elapsed <= '0;
          if (runMode == FN_SAMPLE) busy <= 1'b0;
        end else begin
          elapsed <= elapsed + TIME_W'(1);
        end
      end
    end
  end

  assert_latch_no_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && startEdge && selNow == FN_LATCH) |=> !busy);
  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && selNow != runMode) |=> !busy);
  assert_period_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && runMode == FN_PERIOD && !startReq) |=> !busy);
  assert_window_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
    str.sampStore |=> !busy);
  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({str.latchCap, str.sampClear, str.sampStore, str.perShift}));
endmodule

// File: rtl/pcu_datapath.sv
module pcu_datapath
  import pcu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  strobe_t                  str,
  input  logic signed [DATA_W-1:0] countValue,
  output logic signed [DATA_W-1:0] latchValue,
  output logic signed [DATA_W-1:0] sampleValue,
  output logic signed [DATA_W-1:0] periodPresent,
  output logic signed [DATA_W-1:0] periodPrevious
);
  localparam logic signed [DATA_W-1:0] ONE = DATA_W'(1);

  logic signed [DATA_W-1:0] pulseAcc;
  logic signed [DATA_W-1:0] pulseNext;

  assign pulseNext = str.sampAdd ? pulseAcc + ONE : pulseAcc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulseAcc       <= '0;
      latchValue     <= '0;
      sampleValue    <= '0;
      periodPresent  <= '0;
      periodPrevious <= '0;
    end else begin
      if (str.sampClear)      pulseAcc <= '0;
      else                    pulseAcc <= pulseNext;
      if (str.latchCap)       latchValue  <= countValue;
      if (str.sampStore)      sampleValue <= pulseNext;
      if (str.perShift) begin
        periodPrevious <= periodPresent;
        periodPresent  <= countValue;
      end
    end
  end

  assert_latch_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    str.latchCap |=> latchValue == $past(countValue));
  assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !str.latchCap |=> $stable(latchValue));
  assert_period_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    str.perShift |=> (periodPrevious == $past(periodPresent)) && (periodPresent == $past(countValue)));
  assert_sample_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !str.sampStore |=> $stable(sampleValue));
  assert_period_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !str.perShift |=> $stable(periodPresent) && $stable(periodPrevious));
endmodule

// File: rtl/pulse_capture_unit.sv
module pulse_capture_unit
  import pcu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TIME_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     countPulse,
  input  logic signed [DATA_W-1:0] countValue,
  input  logic [1:0]               funcSel,
  input  logic                     startCmd,
  input  logic                     extStart,
  input  logic [TIME_W-1:0]        timeSet,
  input  logic                     msTick,
  output logic signed [DATA_W-1:0] latchValue,
  output logic signed [DATA_W-1:0] sampleValue,
  output logic signed [DATA_W-1:0] periodPresent,
  output logic signed [DATA_W-1:0] periodPrevious,
  output logic                     busy
);
  strobe_t str;

  pcu_ctrl #(.TIME_W(TIME_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .countPulse(countPulse), .funcSel(funcSel),
    .startCmd(startCmd), .extStart(extStart), .timeSet(timeSet),
    .msTick(msTick), .str(str), .busy(busy)
  );

  pcu_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .str(str), .countValue(countValue),
    .latchValue(latchValue), .sampleValue(sampleValue),
    .periodPresent(periodPresent), .periodPrevious(periodPrevious)
  );
endmodule

// File: tb/test_pulse_capture_unit.sv
module test_pulse_capture_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic countPulse = 1'b0;
  logic signed [31:0] countValue = '0;
  logic [1:0] funcSel = 2'd3;
  logic startCmd = 1'b0;
  logic extStart = 1'b0;
  logic [15:0] timeSet = '0;
  logic msTick = 1'b0;
  logic signed [31:0] latchValue, sampleValue, periodPresent, periodPrevious;
  logic busy;

  int checks = 0;
  int errors = 0;

  // requirement model
  bit mBusy = 0, mPrevReq = 0;
  int mMode = 3, mTicks = 0;
  int mAcc = 0, mSample = 0, mPres = 0, mPrev = 0, mLatch = 0;
  int cycNo = 0;

  always #5 clk = ~clk;

  pulse_capture_unit i_pulse_capture_unit (
    .clk(clk), .rst_n(rst_n), .countPulse(countPulse), .countValue(countValue),
    .funcSel(funcSel), .startCmd(startCmd), .extStart(extStart),
    .timeSet(timeSet), .msTick(msTick), .latchValue(latchValue),
    .sampleValue(sampleValue), .periodPresent(periodPresent),
    .periodPrevious(periodPrevious), .busy(busy)
  );

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // one cycle: update the model from the inputs seen at this edge, clock, compare
  task automatic cyc(input bit p, input bit t, input string tag);
    bit req, edgeSeen;
    int eff;
    countPulse = p;
    msTick = t;
    req = startCmd | extStart;
    edgeSeen = req && !mPrevReq;
    mPrevReq = req;
    eff = (timeSet == 0) ? 1 : int'(timeSet);
    if (mBusy && int'(funcSel) != mMode) mBusy = 0;
    else if (!mBusy) begin
      if (edgeSeen) begin
        if (funcSel == 2'd0) mLatch = countValue;
        else if (funcSel == 2'd1 || funcSel == 2'd2) begin
          mBusy = 1; mMode = int'(funcSel); mTicks = 0; mAcc = 0;
        end
      end
    end else if (mMode == 2 && !req) mBusy = 0;
    else begin
      if (mMode == 1 && p) mAcc++;
      if (t) begin
        mTicks++;
        if (mTicks == eff) begin
          mTicks = 0;
          if (mMode == 1) begin mSample = mAcc; mBusy = 0; end
          else begin mPrev = mPres; mPres = countValue; end
        end
      end
    end
    step();
    cycNo++;
    check(tag, "busy", busy, mBusy);
    check(tag, "latchValue", latchValue, mLatch);
    check(tag, "sampleValue", sampleValue, mSample);
    check(tag, "periodPresent", periodPresent, mPres);
    check(tag, "periodPrevious", periodPrevious, mPrev);
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    step(); step();
    check("R1", "busy", busy, 0);
    check("R1", "latchValue", latchValue, 0);
    check("R1", "sampleValue", sampleValue, 0);
    check("R1", "periodPresent", periodPresent, 0);
    check("R1", "periodPrevious", periodPrevious, 0);
    rst_n = 1'b1;
    cyc(0, 0, "R1");

    // R2 / R3: latch captures, held start does not recapture, code 3 does nothing
    for (int k = 0; k < 6; k++) begin
      funcSel = 2'd0;
      countValue = -1000 + k * 377;
      if (k % 2 == 0) startCmd = 1'b1; else extStart = 1'b1;
      cyc(0, 0, "R2");
      countValue = countValue + 55;
      cyc(0, 1, "R3");
      startCmd = 1'b0; extStart = 1'b0;
      cyc(0, 0, "R3");
    end
    funcSel = 2'd3; countValue = 999; startCmd = 1'b1;
    cyc(0, 1, "R3"); cyc(0, 0, "R3");
    startCmd = 1'b0; cyc(0, 0, "R3");

    // R4 / R5: sampling sweep over window lengths and pulse densities
    for (int ts = 0; ts <= 4; ts++) begin
      for (int dens = 1; dens <= 3; dens++) begin
        funcSel = 2'd1; timeSet = 16'(ts); startCmd = 1'b1;
        cyc(0, 0, (ts == 0) ? "R5" : "R4");
        startCmd = 1'b0;
        for (int c = 0; c < 40 && mBusy; c++)
          cyc((c % dens) == 0, (c % 4) == 3, (ts == 0) ? "R5" : "R4");
        cyc(1, 1, "R4");
      end
    end

    // R9: re-start during sampling is ignored
    funcSel = 2'd1; timeSet = 16'd3; extStart = 1'b1;
    cyc(0, 0, "R9");
    extStart = 1'b0;
    for (int c = 0; c < 30 && mBusy; c++) begin
      startCmd = (c == 5);
      cyc(1, (c % 4) == 3, "R9");
    end
    startCmd = 1'b0; cyc(0, 0, "R9");

    // R6 / R7: periodic runs, then release
    for (int ts = 1; ts <= 3; ts++) begin
      funcSel = 2'd2; timeSet = 16'(ts); startCmd = 1'b1;
      for (int c = 0; c < 40; c++) begin
        countValue = -500 + 13 * cycNo;
        cyc(0, (c % 3) == 2, "R6");
      end
      startCmd = 1'b0;
      countValue = 12345;
      cyc(0, 0, "R7");
      cyc(0, 1, "R7");
      cyc(0, 1, "R7");
    end

    // R8: function change aborts sampling and periodic runs
    funcSel = 2'd1; timeSet = 16'd4; startCmd = 1'b1;
    cyc(0, 0, "R8");
    startCmd = 1'b0;
    for (int c = 0; c < 6; c++) cyc(1, (c % 4) == 3, "R8");
    funcSel = 2'd2;
    cyc(1, 1, "R8"); cyc(1, 1, "R8");
    startCmd = 1'b0; cyc(0, 0, "R8");
    startCmd = 1'b1; timeSet = 16'd1;
    cyc(0, 0, "R8"); cyc(0, 1, "R8");
    funcSel = 2'd0; countValue = -77;
    cyc(0, 1, "R8"); cyc(0, 1, "R8");
    startCmd = 1'b0; cyc(0, 0, "R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule